// File: doc/BRIEF.md
# Interrupt Priority Level Arbiter

This block folds two sources of interrupt requests into one priority decision. One source is a software request word, of which only a contiguous field of bits is meaningful. The other is a vector of external interrupt lines. Each pending request sets its own bit in a summary vector. The block also derives one requested priority level from the highest pending request. External lines always rank above software requests.

A check is requested with a pulse. The request is held in a pending flag until the evaluate-enable input allows the check to run. During the evaluation cycle the requested level is compared with the current priority level of the processor. A take is raised only when the level is nonzero and strictly greater than the current level. When a take occurs, the block registers the summary and the level for the caller, which stores them in its summary and interrupt-id registers. It also emits a one-cycle take strobe that starts trap entry. A nonzero asynchronous trap request during evaluation is not supported. It produces an error strobe instead of a take.

Top module: `ipl_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, chk_pend_o, take_o, ast_err_o, isum_o and ilvl_o are all zero.
- R2: A pulse on chk_set_i sets chk_pend_o on the next cycle. The flag stays set while eval_en_i is low. After a cycle in which both chk_pend_o and eval_en_i are high, the flag is clear unless chk_set_i was high in that cycle.
- R3: Only bits 4 to 18 of sw_req_i are software requests. When the highest of these set bits is at index i and no external line is set, the requested level is i - 3, so bit 4 gives 1 and bit 18 gives 15. Bits 0 to 3 and 19 to 31 have no effect.
- R4: External line k (ext_irq_i[k], k = 0 to 10) stands for request index 20 + k and gives level 20 + k. The highest set line decides the level, and any set external line overrides every software request.
- R5: The summary vector holds sw_req_i bits 4 to 18 in positions 4 to 18 and ext_irq_i[k] in position 20 + k. All other positions are zero.
- R6: A take happens only when the requested level is nonzero and strictly greater than ipl_lvl_i. An equal or lower level gives no take.
- R7: take_o goes high for exactly one cycle, in the cycle after the evaluation cycle. It does not repeat without a new evaluation.
- R8: isum_o and ilvl_o are loaded with the summary and level only on a take. Otherwise they hold their values.
- R9: If ast_req_i is nonzero in an evaluation cycle, ast_err_o goes high for one cycle in the next cycle. No take occurs, and isum_o and ilvl_o hold.
- R10: No evaluation runs while chk_pend_o or eval_en_i is low. No take and no error strobe follow, whatever the request inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_set_i | input | 1 | Request an interrupt check |
| eval_en_i | input | 1 | Allow a pending check to evaluate this cycle |
| sw_req_i | input | 32 | Software request word; bits 4 to 18 are used |
| ext_irq_i | input | 11 | External interrupt lines, index 20 + k |
| ipl_lvl_i | input | 5 | Current processor priority level |
| ast_req_i | input | 4 | Asynchronous trap request; nonzero is unsupported |
| chk_pend_o | output | 1 | Check pending flag |
| take_o | output | 1 | One-cycle interrupt take strobe |
| isum_o | output | 32 | Summary vector latched on take |
| ilvl_o | output | 5 | Interrupt level latched on take |
| ast_err_o | output | 1 | One-cycle unsupported trap strobe |

## Verification
The assertions assume that the request inputs and ipl_lvl_i are stable during the evaluation cycle. They also assume that ipl_lvl_i is the level value the take is compared against. The bench changes inputs only on falling edges and holds them through each evaluation, so every comparison it makes uses the values the design sampled. The random stimulus keeps the external vector at zero in most trials, so that the software path is exercised. It draws ast_req_i nonzero only rarely, so that takes dominate. Directed cases cover the corners: both ends of the software field, bits outside that field, equal levels, and a pending check held back by a low eval_en_i.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
   localparam int unsigned VEC_W_D  = 32;
   localparam int unsigned SW_LO_D  = 4;
   localparam int unsigned SW_HI_D  = 18;
   localparam int unsigned EXT_LO_D = 20;
   localparam int unsigned EXT_HI_D = 30;
   localparam int unsigned LVL_W_D  = 5;
   localparam int unsigned AST_W_D  = 4;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/ipl_prio_enc.sv
module ipl_prio_enc #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = ipl_pkg::idx_width(N)
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   if (N < 1) begin : g_bad_n
      $error("ipl_prio_enc: N must be at least 1");
   end

   if (N == 1) begin : g_single
      assign any = req[0];
      assign idx = '0;
   end else begin : g_multi
      always_comb begin
         idx = '0;
         for (int k = 0; k < N; k++) begin
            if (req[k]) idx = IDX_W'(k);
         end
      end
      assign any = |req;
   end
endmodule

// File: rtl/ipl_pend_flag.sv
module ipl_pend_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic eval_en_i,
   output logic pend_o,
   output logic eval_o
);
   logic pend_q;

   assign eval_o = pend_q & eval_en_i;
   assign pend_o = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= set_i | (pend_q & ~eval_en_i);
   end
endmodule

// File: rtl/ipl_take_reg.sv
module ipl_take_reg #(
   parameter int unsigned VEC_W = 32,
   parameter int unsigned LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eval_i,
   input  logic             ast_bad_i,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic [LVL_W-1:0] cur_i,
   input  logic [VEC_W-1:0] sum_i,
   output logic             take_o,
   output logic             ast_err_o,
   output logic [VEC_W-1:0] sum_o,
   output logic [LVL_W-1:0] lvl_o
);
   logic wins;
   assign wins = (lvl_i != '0) && (lvl_i > cur_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o    <= 1'b0;
         ast_err_o <= 1'b0;
         sum_o     <= '0;
         lvl_o     <= '0;
      end else begin
         take_o    <= eval_i & ~ast_bad_i & wins;
         ast_err_o <= eval_i & ast_bad_i;
         if (eval_i && !ast_bad_i && wins) begin
            sum_o <= sum_i;
            lvl_o <= lvl_i;
         end
      end
   end
endmodule

// File: rtl/ipl_arbiter.sv
module ipl_arbiter #(
   parameter int unsigned VEC_W  = ipl_pkg::VEC_W_D,
   parameter int unsigned SW_LO  = ipl_pkg::SW_LO_D,
   parameter int unsigned SW_HI  = ipl_pkg::SW_HI_D,
   parameter int unsigned EXT_LO = ipl_pkg::EXT_LO_D,
   parameter int unsigned EXT_HI = ipl_pkg::EXT_HI_D,
   parameter int unsigned LVL_W  = ipl_pkg::LVL_W_D,
   parameter int unsigned AST_W  = ipl_pkg::AST_W_D
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     chk_set_i,
   input  logic                     eval_en_i,
   input  logic [VEC_W-1:0]         sw_req_i,
   input  logic [EXT_HI-EXT_LO:0]   ext_irq_i,
   input  logic [LVL_W-1:0]         ipl_lvl_i,
   input  logic [AST_W-1:0]         ast_req_i,
   output logic                     chk_pend_o,
   output logic                     take_o,
   output logic [VEC_W-1:0]         isum_o,
   output logic [LVL_W-1:0]         ilvl_o,
   output logic                     ast_err_o
);
   localparam int unsigned SW_N   = SW_HI - SW_LO + 1;
   localparam int unsigned EXT_N  = EXT_HI - EXT_LO + 1;
   localparam int unsigned SW_IW  = ipl_pkg::idx_width(SW_N);
   localparam int unsigned EXT_IW = ipl_pkg::idx_width(EXT_N);

   if (SW_HI < SW_LO || EXT_HI < EXT_LO) begin : g_bad_range
      $error("ipl_arbiter: empty request field");
   end
   if (SW_HI >= EXT_LO) begin : g_bad_order
      $error("ipl_arbiter: software field must lie below external field");
   end
   if (EXT_HI >= VEC_W) begin : g_bad_vec
      $error("ipl_arbiter: external field exceeds summary width");
   end
   if (EXT_HI >= (1 << LVL_W) || SW_N >= (1 << LVL_W)) begin : g_bad_lvl
      $error("ipl_arbiter: level width too small");
   end

   logic [SW_N-1:0]   sw_field;
   logic              sw_any, ext_any, eval;
   logic [SW_IW-1:0]  sw_idx;
   logic [EXT_IW-1:0] ext_idx;
   logic [LVL_W-1:0]  req_lvl;
   logic [VEC_W-1:0]  summary;

   assign sw_field = sw_req_i[SW_HI:SW_LO];

   ipl_pend_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (chk_set_i),
      .eval_en_i (eval_en_i),
      .pend_o    (chk_pend_o),
      .eval_o    (eval)
   );

   ipl_prio_enc #(.N(SW_N), .IDX_W(SW_IW)) u_sw_enc (
      .req (sw_field),
      .any (sw_any),
      .idx (sw_idx)
   );

   ipl_prio_enc #(.N(EXT_N), .IDX_W(EXT_IW)) u_ext_enc (
      .req (ext_irq_i),
      .any (ext_any),
      .idx (ext_idx)
   );

   always_comb begin
      if (ext_any)     req_lvl = LVL_W'(EXT_LO) + LVL_W'(ext_idx);
      else if (sw_any) req_lvl = LVL_W'(sw_idx) + LVL_W'(1);
      else             req_lvl = '0;
   end

   always_comb begin
      summary                = '0;
      summary[SW_HI:SW_LO]   = sw_field;
      summary[EXT_HI:EXT_LO] = ext_irq_i;
   end

   ipl_take_reg #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_take (
      .clk       (clk),
      .rst_n     (rst_n),
      .eval_i    (eval),
      .ast_bad_i (ast_req_i != '0),
      .lvl_i     (req_lvl),
      .cur_i     (ipl_lvl_i),
      .sum_i     (summary),
      .take_o    (take_o),
      .ast_err_o (ast_err_o),
      .sum_o     (isum_o),
      .lvl_o     (ilvl_o)
   );
endmodule

// File: rtl/ipl_arbiter_chk.sv
module ipl_arbiter_chk #(
   parameter int unsigned VEC_W  = 32,
   parameter int unsigned EXT_N  = 11,
   parameter int unsigned LVL_W  = 5,
   parameter int unsigned AST_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chk_set_i,
   input logic             eval_en_i,
   input logic [LVL_W-1:0] ipl_lvl_i,
   input logic [AST_W-1:0] ast_req_i,
   input logic             chk_pend_o,
   input logic             take_o,
   input logic [VEC_W-1:0] isum_o,
   input logic [LVL_W-1:0] ilvl_o,
   input logic             ast_err_o
);
   assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_pend_o && eval_en_i && !chk_set_i) |=> !chk_pend_o);

   assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      chk_set_i |=> chk_pend_o);

   assert_strict_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (ilvl_o != '0) && (ilvl_o > $past(ipl_lvl_i)));

   assert_take_after_eval_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> $past(chk_pend_o && eval_en_i));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !take_o |-> ($stable(isum_o) && $stable(ilvl_o)));

   assert_ast_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ast_err_o |-> ($past(ast_req_i) != '0) && !take_o);

   assert_no_eval_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(chk_pend_o && eval_en_i) |=> !take_o && !ast_err_o);
endmodule

bind ipl_arbiter ipl_arbiter_chk #(
   .VEC_W (VEC_W),
   .EXT_N (EXT_HI - EXT_LO + 1),
   .LVL_W (LVL_W),
   .AST_W (AST_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chk_set_i  (chk_set_i),
   .eval_en_i  (eval_en_i),
   .ipl_lvl_i  (ipl_lvl_i),
   .ast_req_i  (ast_req_i),
   .chk_pend_o (chk_pend_o),
   .take_o     (take_o),
   .isum_o     (isum_o),
   .ilvl_o     (ilvl_o),
   .ast_err_o  (ast_err_o)
);

// File: tb/ipl_arbiter_bench.sv
module ipl_arbiter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chk_set_i = 1'b0;
   logic        eval_en_i = 1'b0;
   logic [31:0] sw_req_i = '0;
   logic [10:0] ext_irq_i = '0;
   logic [4:0]  ipl_lvl_i = '0;
   logic [3:0]  ast_req_i = '0;
   logic        chk_pend_o, take_o, ast_err_o;
   logic [31:0] isum_o;
   logic [4:0]  ilvl_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [31:0] m_sum = '0;
   logic [4:0]  m_lvl = '0;

   always #10 clk = ~clk;

   ipl_arbiter u_ipl_arbiter (.*);

   function automatic logic [4:0] exp_lvl(logic [31:0] sw, logic [10:0] ext);
      logic [4:0] l = '0;
      for (int i = 4; i <= 18; i++) if (sw[i]) l = 5'(i - 3);
      for (int k = 0; k <= 10; k++) if (ext[k]) l = 5'(20 + k);
      return l;
   endfunction

   function automatic logic [31:0] exp_sum(logic [31:0] sw, logic [10:0] ext);
      return (sw & 32'h0007_fff0) | ({21'b0, ext} << 20);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic evaluate(logic [31:0] sw, logic [10:0] ext, logic [4:0] ipl,
                           logic [3:0] ast, string req);
      logic [4:0] l;
      logic tk;
      @(negedge clk);
      sw_req_i = sw; ext_irq_i = ext; ipl_lvl_i = ipl; ast_req_i = ast;
      chk_set_i = 1'b1; eval_en_i = 1'b1;
      @(negedge clk);
      chk_set_i = 1'b0;
      @(negedge clk);
      l  = exp_lvl(sw, ext);
      tk = (l != 0) && (l > ipl) && (ast == 0);
      if (tk) begin m_sum = exp_sum(sw, ext); m_lvl = l; end
      check({req, " take"}, 32'(take_o), 32'(tk));
      check({req, " ast_err R9"}, 32'(ast_err_o), 32'(ast != 0));
      check({req, " summary R5/R8"}, isum_o, m_sum);
      check({req, " level R8"}, 32'(ilvl_o), 32'(m_lvl));
      @(negedge clk);
      check("R7 strobe single", 32'(take_o), 32'd0);
      check("R2 flag cleared", 32'(chk_pend_o), 32'd0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 reset pend", 32'(chk_pend_o), 0);
      check("R1 reset take", 32'(take_o), 0);
      check("R1 reset sum", isum_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset lvl", 32'(ilvl_o), 0);
      check("R1 after reset err", 32'(ast_err_o), 0);

      evaluate(32'h0000_0010, 11'h0, 5'd0, 4'h0, "R3 lowest sw bit");
      evaluate(32'h0004_0000, 11'h0, 5'd3, 4'h0, "R3 highest sw bit");
      evaluate(32'hFFF8_000F, 11'h0, 5'd0, 4'h0, "R3 outside bits ignored");
      evaluate(32'h0000_1000, 11'h0, 5'd9, 4'h0, "R6 equal level");
      evaluate(32'h0000_1000, 11'h0, 5'd8, 4'h0, "R6 one above");
      evaluate(32'h0007_fff0, 11'h001, 5'd19, 4'h0, "R4 ext overrides sw");
      evaluate(32'h0, 11'h400, 5'd29, 4'h0, "R4 top ext line");
      evaluate(32'h0, 11'h400, 5'd30, 4'h0, "R6 ext equal");
      evaluate(32'h0000_0100, 11'h0, 5'd0, 4'h2, "R9 ast request");
      evaluate(32'h0, 11'h0, 5'd0, 4'h0, "R6 zero level");

      // R10 / R2: pending held while evaluation is blocked
      @(negedge clk);
      sw_req_i = 32'h0000_0800; ext_irq_i = '0; ipl_lvl_i = 5'd0; ast_req_i = '0;
      chk_set_i = 1'b1; eval_en_i = 1'b0;
      @(negedge clk);
      chk_set_i = 1'b0;
      repeat (3) begin
         @(negedge clk);
         check("R2 flag held", 32'(chk_pend_o), 1);
         check("R10 no take while blocked", 32'(take_o), 0);
      end
      eval_en_i = 1'b1;
      @(negedge clk);
      m_sum = 32'h0000_0800; m_lvl = 5'd8;
      check("R10 take once enabled", 32'(take_o), 1);
      check("R10 level once enabled", 32'(ilvl_o), 8);
      // R10: inputs change with no pending check
      sw_req_i = 32'h0007_fff0; ext_irq_i = 11'h7ff;
      repeat (2) @(negedge clk);
      check("R10 idle no take", 32'(take_o), 0);
      check("R10 idle sum held", isum_o, m_sum);

      for (int t = 0; t < 300; t++) begin
         logic [31:0] s;
         logic [10:0] e;
         s = $urandom;
         e = ($urandom_range(0, 3) == 0) ? 11'($urandom) : 11'h0;
         evaluate(s, e, 5'($urandom), ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'h0,
                  "R3 R4 R6 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule